// File: doc/BRIEF.md
# Transmitter Clear-To-Send Pause Gate

This block sits between a UART's transmit holding logic and its shift register and decides when the next character may start. It watches the active-low clear-to-send input from the far end. While automatic pausing is on and the far end is not clear (the input is high), no new character is granted. A character that has already started always runs to the end of its stop bit; the pause takes effect at the next character boundary and never partway through a frame. When the input returns low, granting resumes.

The start of a character is a valid/ready handshake. The holding logic raises `start_valid` when it has a character waiting and holds it until it sees `start_ready` high at a clock edge; that edge is the transfer. `start_ready` does not depend on `start_valid`, so the holding logic may use it as back-pressure. When automatic pausing is on, at most one character is in flight: after a transfer, `start_ready` stays low until the shifter pulses `stop_done`. With pausing off, `start_ready` is held high and the holding logic paces itself.

The block also keeps a sticky status bit that records each high-going edge of the clear-to-send input, when the interrupt enable and the enhanced-functions gate are both set.

Top module: `tx_cts_gate`

## Requirements
- R1: `cts_n` passes through a two-stage synchronizer; a change on `cts_n` made between edges reaches `start_ready` after exactly two rising clock edges, not after one.
- R2: During and just after reset, `cts_int_stat` is 0, no character is in flight, and the synchronized input starts in the not-clear (high) state, so with `auto_en` = 1 `start_ready` is 0 until two edges have sampled a low `cts_n`.
- R3: With `auto_en` = 1, after a transfer (`start_valid` and `start_ready` both 1 at an edge) `start_ready` stays 0 until the edge at which `stop_done` is 1.
- R4: With `auto_en` = 1 and synchronized `cts_n` high, `start_ready` is 0, both when idle and after a character in flight finishes with `stop_done`; the character in flight is never cut off.
- R5: With `auto_en` = 1, no character in flight and synchronized `cts_n` low, `start_ready` is 1.
- R6: A low-to-high edge of synchronized `cts_n` sets `cts_int_stat` one edge after it is seen, when `cts_int_en` = 1 and `enh_gate` = 1.
- R7: `cts_int_stat` is not set by the edge when `cts_int_en` = 0 or `enh_gate` = 0, and is not set by `cts_n` that stays high.
- R8: `cts_int_stat` stays 1 until `stat_clr` is 1 at an edge; when a new setting edge and `stat_clr` meet at the same edge, the bit ends up 1.
- R9: With `auto_en` = 0, `start_ready` is 1 whatever `cts_n`, `start_valid` and the frame state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cts_n | input | 1 | Active-low clear-to-send from the far end, asynchronous |
| auto_en | input | 1 | Enable automatic pausing of the transmitter |
| cts_int_en | input | 1 | Enable for the clear-to-send status event |
| enh_gate | input | 1 | Enhanced-functions gate; the status event is counted only when set |
| start_valid | input | 1 | Holding logic has a character ready to start |
| start_ready | output | 1 | Grant: a character may start; transfer when both are 1 at an edge |
| stop_done | input | 1 | One-cycle pulse from the shifter when the stop bit is fully sent |
| stat_clr | input | 1 | Clear strobe for the status bit |
| cts_int_stat | output | 1 | Sticky clear-to-send deassertion status |

## Verification
The bench builds the block with its default two-stage synchronizer and a reset level of not-clear, which is the configuration the requirements describe and which makes the one-edge versus two-edge latency of `cts_n` directly visible at `start_ready`. Every combination of the interrupt enable and the enhanced gate is swept against a rising `cts_n`, and every combination of `cts_n` and `start_valid` is swept with pausing off. The pause is driven mid-frame, at idle and across the `stop_done` edge, and the clear strobe is placed on exactly the edge a new event lands.

// File: rtl/tx_cts_gate_pkg.sv
package tx_cts_gate_pkg;

  // Frame state of the transmitter as seen by the gate
  typedef enum logic {
    PH_IDLE  = 1'b0,
    PH_FRAME = 1'b1
  } tx_phase_e;

  // Not-clear level of the active-low clear-to-send line
  localparam logic CTS_NOT_CLEAR = 1'b1;

endpackage

// File: rtl/tx_cts_sync.sv
module tx_cts_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] stg_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= RST_VAL;
        else        stg_q <= din;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= {STAGES{RST_VAL}};
        else        stg_q <= {stg_q[STAGES-2:0], din};
      end
      // each stage carries the previous stage one edge later (R1)
      for (genvar i = 1; i < STAGES; i++) begin : g_chk
        p_stage_shift_r1: assert property (@(posedge clk) disable iff (!rst_n)
          1'b1 |=> stg_q[i] == $past(stg_q[i-1]));
      end
    end
  endgenerate

  p_first_stage_r1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> stg_q[0] == $past(din));

  assign dout = stg_q[STAGES-1];

endmodule

// File: rtl/tx_cts_launch.sv
module tx_cts_launch
  import tx_cts_gate_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic auto_en,
  input  logic cts_hi,
  input  logic start_valid,
  input  logic stop_done,
  output logic start_ready
);

  tx_phase_e phase_q;
  logic      take;

  assign take = start_valid & start_ready;

  // A granted character is in flight until the stop bit is out;
  // a new grant in the same cycle as stop_done wins.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         phase_q <= PH_IDLE;
    else if (take)      phase_q <= PH_FRAME;
    else if (stop_done) phase_q <= PH_IDLE;
  end

  // Pause only at a character boundary; free-running when disabled
  assign start_ready = ~auto_en | ((phase_q == PH_IDLE) & ~cts_hi);

  // one character at a time while pausing is on (R3)
  p_one_in_flight_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (take && auto_en) |=> (!auto_en || !start_ready));

  // a frame in flight with no stop pulse keeps the gate closed (R3)
  p_frame_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_en && !start_ready && phase_q == PH_FRAME && !stop_done)
      |=> (!auto_en || !start_ready));

  // leaving a frame needs the shifter's stop pulse (R4)
  p_frame_ends_on_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(phase_q == PH_FRAME) |-> $past(stop_done));

endmodule

// File: rtl/tx_cts_irq.sv
module tx_cts_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic cts_hi,
  input  logic int_en,
  input  logic gate,
  input  logic clr,
  output logic stat
);

  logic cts_prev_q;
  logic rise;
  logic stat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cts_prev_q <= 1'b1;
    else        cts_prev_q <= cts_hi;
  end

  assign rise = cts_hi & ~cts_prev_q;

  // set has priority over clear so an event is never lost
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     stat_q <= 1'b0;
    else if (rise && int_en && gate) stat_q <= 1'b1;
    else if (clr)                    stat_q <= 1'b0;
  end

  assign stat = stat_q;

  // a new status needs both enables on the edge cycle (R6, R7)
  p_set_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_q) |-> $past(int_en && gate && cts_hi));

  // sticky until cleared (R8)
  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q && !clr) |=> stat_q);

  // a steady high line sets nothing (R7)
  p_level_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat_q && cts_hi && cts_prev_q) |=> !stat_q);

endmodule

// File: rtl/tx_cts_gate.sv
module tx_cts_gate
  import tx_cts_gate_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cts_n,
  input  logic auto_en,
  input  logic cts_int_en,
  input  logic enh_gate,
  input  logic start_valid,
  output logic start_ready,
  input  logic stop_done,
  input  logic stat_clr,
  output logic cts_int_stat
);

  logic cts_hi;

  tx_cts_sync #(
    .STAGES  (SYNC_STAGES),
    .RST_VAL (CTS_NOT_CLEAR)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (cts_n),
    .dout  (cts_hi)
  );

  tx_cts_launch u_launch (
    .clk         (clk),
    .rst_n       (rst_n),
    .auto_en     (auto_en),
    .cts_hi      (cts_hi),
    .start_valid (start_valid),
    .stop_done   (stop_done),
    .start_ready (start_ready)
  );

  tx_cts_irq u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .cts_hi (cts_hi),
    .int_en (cts_int_en),
    .gate   (enh_gate),
    .clr    (stat_clr),
    .stat   (cts_int_stat)
  );

  // no grant reaches the shifter while the synchronized line says not clear (R4)
  p_no_start_paused_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_en && start_valid && start_ready) |-> !cts_hi);

  // free running when pausing is off (R9)
  p_free_run_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_en |-> start_ready);

endmodule

// File: tb/tx_cts_gate_test.sv
module tx_cts_gate_test;

  localparam time CYC = 8ns;

  logic clk = 1'b0;
  logic rst_n, cts_n, auto_en, cts_int_en, enh_gate;
  logic start_valid, stop_done, stat_clr;
  logic start_ready, cts_int_stat;

  int checks = 0;
  int errors = 0;

  always #(CYC/2) clk = ~clk;

  tx_cts_gate uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .cts_n        (cts_n),
    .auto_en      (auto_en),
    .cts_int_en   (cts_int_en),
    .enh_gate     (enh_gate),
    .start_valid  (start_valid),
    .start_ready  (start_ready),
    .stop_done    (stop_done),
    .stat_clr     (stat_clr),
    .cts_int_stat (cts_int_stat)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0b expected %0b", tag, act, exp);
    end
  endtask

  // advance n falling edges, then settle
  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic pulse_stop();
    stop_done = 1'b1; step(1); stop_done = 1'b0;
  endtask

  initial begin
    #(CYC * 100000);
    errors++;
    $display("FAIL watchdog expired, run hung");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cts_n = 1'b0; auto_en = 1'b0; cts_int_en = 1'b0;
    enh_gate = 1'b0; start_valid = 1'b0; stop_done = 1'b0; stat_clr = 1'b0;
    step(3);
    chk("R2 status in reset", cts_int_stat, 1'b0);
    auto_en = 1'b1;
    #1;
    chk("R2 not clear in reset", start_ready, 1'b0);
    rst_n = 1'b1;
    step(1);
    chk("R1 R2 one edge after reset", start_ready, 1'b0);
    step(1);
    chk("R1 R5 two edges after reset", start_ready, 1'b1);
    chk("R2 no event from reset", cts_int_stat, 1'b0);

    // R9 sweep with pausing off
    auto_en = 1'b0;
    for (int c = 0; c < 2; c++) begin
      for (int v = 0; v < 2; v++) begin
        cts_n = c[0]; start_valid = v[0];
        step(3);
        chk("R9 free run", start_ready, 1'b1);
      end
    end
    start_valid = 1'b0; cts_n = 1'b0;
    pulse_stop();
    step(3);

    // R3 single character in flight
    auto_en = 1'b1;
    #1;
    chk("R5 idle and clear", start_ready, 1'b1);
    start_valid = 1'b1;
    step(1);
    for (int k = 0; k < 4; k++) begin
      chk("R3 held during frame", start_ready, 1'b0);
      step(1);
    end
    pulse_stop();
    chk("R3 R5 reopens after stop", start_ready, 1'b1);
    start_valid = 1'b0;
    step(1);
    chk("R3 stop cleared frame without new take", start_ready, 1'b1);

    // R4 pause mid-frame, completes at stop bit
    start_valid = 1'b1;
    step(1);
    start_valid = 1'b0;
    cts_n = 1'b1;
    step(3);
    chk("R4 frame still running", start_ready, 1'b0);
    pulse_stop();
    start_valid = 1'b1;
    for (int k = 0; k < 5; k++) begin
      #1;
      chk("R4 paused at boundary", start_ready, 1'b0);
      step(1);
    end
    // R5 resume with two-edge latency
    cts_n = 1'b0;
    step(1);
    chk("R1 one edge after clear", start_ready, 1'b0);
    step(1);
    chk("R1 R5 resumes after two edges", start_ready, 1'b1);
    step(1);
    start_valid = 1'b0;
    chk("R3 take closes gate", start_ready, 1'b0);
    pulse_stop();

    // R4 idle with line already high
    cts_n = 1'b1;
    step(3);
    chk("R4 idle paused", start_ready, 1'b0);
    cts_n = 1'b0;
    step(3);

    // R6 R7 R8 sweep of enable and gate
    for (int ie = 0; ie < 2; ie++) begin
      for (int g = 0; g < 2; g++) begin
        logic expv;
        expv = ie[0] & g[0];
        cts_int_en = ie[0]; enh_gate = g[0];
        stat_clr = 1'b1; step(1); stat_clr = 1'b0;
        cts_n = 1'b1;
        step(2);
        chk("R6 not yet after sync", cts_int_stat, 1'b0);
        step(1);
        chk(expv ? "R6 edge sets status" : "R7 disabled edge", cts_int_stat, expv);
        step(4);
        chk("R8 stays until cleared", cts_int_stat, expv);
        stat_clr = 1'b1; step(1); stat_clr = 1'b0;
        chk("R8 clear strobe", cts_int_stat, 1'b0);
        step(5);
        chk("R7 steady high sets nothing", cts_int_stat, 1'b0);
        cts_n = 1'b0;
        step(4);
      end
    end

    // R8 set and clear on the same edge
    cts_int_en = 1'b1; enh_gate = 1'b1;
    cts_n = 1'b1;
    step(2);
    stat_clr = 1'b1;
    step(1);
    stat_clr = 1'b0;
    chk("R8 set wins over clear", cts_int_stat, 1'b1);
    stat_clr = 1'b1; step(1); stat_clr = 1'b0;
    chk("R8 later clear", cts_int_stat, 1'b0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule